// File: doc/BRIEF.md
# Sixteen-Phase Execution Sequencer

This block times a single instruction of a small multi-cycle processor. Once an instruction is ready it steps a phase index through sixteen phases. While the index moves it raises exactly one of three group enables: operand load for the first four phases, compute for the next eight, and store for the last four.

After the store group the sequencer waits for the memory side to report that the write has finished. It then spends one cycle flushing the gating logic and one cycle asking the program counter for the next instruction. Finally it returns to an idle state, where it waits for the next instruction-ready strobe.

The group sizes are parameters. Their defaults give the 4/8/4 split of sixteen phases.

Top module: `exec_phase_seq`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows phase 0 with load, compute, store, flush and fetch-request all low.
- R2: In the idle state the phase stays 0 and every output stays low until instr_ready is seen high at a clock edge. The cycle after that edge shows phase 0 with load enable high.
- R3: While running, the phase index rises by exactly one each cycle from 0 to 15.
- R4: Load enable is high exactly in running phases 0 to 3.
- R5: Compute enable is high exactly in running phases 4 to 11.
- R6: Store enable is high exactly in running phases 12 to 15.
- R7: At most one of load, compute, store, flush and fetch-request is high in any cycle. Exactly one group enable is high in every running phase.
- R8: If write_done is high at any clock edge during phases 12 to 15, the cycle after phase 15 is a flush cycle.
- R9: If write_done was not seen during phases 12 to 15, the sequencer waits after phase 15 with the phase held at 15 and all enables low. The cycle after write_done is seen high is a flush cycle.
- R10: write_done has no effect when it arrives in the idle state or during phases 0 to 11. A cycle that sees it only there still enters the wait state after phase 15.
- R11: Flush is high for exactly one cycle. Fetch-request is high for exactly the next cycle, with phase 0. The cycle after that is idle, with all outputs low.
- R12: instr_ready has no effect while running, waiting or flushing. The phase sequence and the wait state carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_ready | input | 1 | Strobe: an instruction is decoded and ready to execute |
| write_done | input | 1 | The store of the current instruction has completed |
| phase | output | 4 | Current phase index |
| load_en | output | 1 | Operand-load group enable |
| compute_en | output | 1 | Compute group enable |
| store_en | output | 1 | Store/writeback group enable |
| flush | output | 1 | One-cycle flush pulse for the gating logic |
| fetch_req | output | 1 | One-cycle request to the program counter to fetch |

## Verification
The phase index and the group enables are decoded from the same registers, with no extra delay. A wrong counter or state value therefore shows at the ports in the very cycle it occurs. It appears as a skipped or repeated phase index, a missing or doubled enable, or an enable outside its window. A stale write-complete flag or a wrong control-state transition shows one cycle after phase 15 at the latest: the bench expects either the flush pulse or a held phase of 15 in that cycle. An ignored input that was not really ignored shows in the cycle right after it is applied.

// File: rtl/exec_seq_pkg.sv
// Package: shared types for the execution phase sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package exec_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_FLUSH = 3'd3,
        ST_FETCH = 3'd4
    } seq_state_e;
endpackage

// File: rtl/phase_counter.sv
// Module: phase counter. Steps 0..N-1 while advance is high, holds at the
// last phase, and returns to 0 on clear.
// Assumes: clear and advance are never high together.
module phase_counter #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    output logic [W-1:0] phase,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(N - 1);

    // Flags the final phase of the instruction.
    always_comb at_last = (phase == LAST);

    // Phase register: reset, clear, or step toward the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                  phase <= '0;
        else if (clear)              phase <= '0;
        else if (advance && !at_last) phase <= phase + W'(1);
    end
endmodule

// File: rtl/group_decoder.sv
// Module: decodes the phase index into load/compute/store group enables.
// Assumes: groups are contiguous in the order load, compute, store.
module group_decoder #(
    parameter int LOAD_N  = 4,
    parameter int COMP_N  = 8,
    parameter int STORE_N = 4,
    parameter int W       = 4
) (
    input  logic [W-1:0] phase,
    input  logic         active,
    output logic         load_en,
    output logic         compute_en,
    output logic         store_en
);
    localparam int LOAD_END  = LOAD_N;
    localparam int COMP_END  = LOAD_N + COMP_N;
    localparam int STORE_END = LOAD_N + COMP_N + STORE_N;

    int p;

    // Range compare on the widened phase value; gated by the running state.
    always_comb begin
        p          = int'(phase);
        load_en    = active && (p < LOAD_END);
        compute_en = active && (p >= LOAD_END) && (p < COMP_END);
        store_en   = active && (p >= COMP_END) && (p < STORE_END);
    end
endmodule

// File: rtl/seq_ctrl.sv
// Module: control state machine. Idle -> run -> (wait) -> flush -> fetch.
// Assumes: at_last and in_store come from the counter and decoder of the
// same instance; write_done only counts during the store group or wait.
module seq_ctrl
    import exec_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_ready,
    input  logic       write_done,
    input  logic       at_last,
    input  logic       in_store,
    output seq_state_e state_q
);
    seq_state_e state_d;
    logic       done_seen;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (instr_ready) state_d = ST_RUN;
            ST_RUN:   if (at_last)
                          state_d = (write_done || done_seen) ? ST_FLUSH : ST_WAIT;
            ST_WAIT:  if (write_done) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_FETCH;
            ST_FETCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remembers a write completion seen during the store group.
    always_ff @(posedge clk) begin
        if (!rst_n)                    done_seen <= 1'b0;
        else if (state_q != ST_RUN)    done_seen <= 1'b0;
        else if (in_store && write_done) done_seen <= 1'b1;
    end
endmodule

// File: rtl/exec_phase_seq.sv
// Module: top of the sixteen-phase execution sequencer.
// Assumes: instr_ready is a strobe from the decoder; write_done comes from
// the memory side and may arrive during the store group or afterwards.
module exec_phase_seq
    import exec_seq_pkg::*;
#(
    parameter int LOAD_N  = 4,
    parameter int COMP_N  = 8,
    parameter int STORE_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_ready,
    input  logic write_done,
    output logic [$clog2(LOAD_N+COMP_N+STORE_N)-1:0] phase,
    output logic load_en,
    output logic compute_en,
    output logic store_en,
    output logic flush,
    output logic fetch_req
);
    localparam int TOTAL   = LOAD_N + COMP_N + STORE_N;
    localparam int PHASE_W = $clog2(TOTAL);

    seq_state_e state_q;
    logic       at_last;
    logic       running;
    logic       hold;

    // Decodes the control state into counter controls and pulses.
    always_comb begin
        running   = (state_q == ST_RUN);
        hold      = running || (state_q == ST_WAIT);
        flush     = (state_q == ST_FLUSH);
        fetch_req = (state_q == ST_FETCH);
    end

    phase_counter #(.N(TOTAL), .W(PHASE_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!hold),
        .advance (running),
        .phase   (phase),
        .at_last (at_last)
    );

    group_decoder #(.LOAD_N(LOAD_N), .COMP_N(COMP_N), .STORE_N(STORE_N), .W(PHASE_W)) u_dec (
        .phase      (phase),
        .active     (running),
        .load_en    (load_en),
        .compute_en (compute_en),
        .store_en   (store_en)
    );

    seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_ready (instr_ready),
        .write_done  (write_done),
        .at_last     (at_last),
        .in_store    (store_en),
        .state_q     (state_q)
    );
endmodule

// File: rtl/exec_seq_checker.sv
// Module: property checker for the execution phase sequencer, bound to
// the top. Assumes: state is the control state register of the top.
module exec_seq_checker
    import exec_seq_pkg::*;
#(
    parameter int LOAD_N  = 4,
    parameter int COMP_N  = 8,
    parameter int STORE_N = 4
) (
    input logic clk,
    input logic rst_n,
    input logic instr_ready,
    input logic write_done,
    input logic [$clog2(LOAD_N+COMP_N+STORE_N)-1:0] phase,
    input logic load_en,
    input logic compute_en,
    input logic store_en,
    input logic flush,
    input logic fetch_req,
    input seq_state_e state
);
    localparam int TOTAL   = LOAD_N + COMP_N + STORE_N;
    localparam int PHASE_W = $clog2(TOTAL);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(TOTAL - 1);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (phase == '0 && !load_en && !compute_en && !store_en && !flush && !fetch_req)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !instr_ready) |=> (state == ST_IDLE && phase == '0)); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && phase != LAST) |=> (state == ST_RUN && phase == $past(phase) + PHASE_W'(1))); // R3

    AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (int'(phase) < LOAD_N)); // R4

    AST_COMPUTE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        compute_en |-> (int'(phase) >= LOAD_N && int'(phase) < LOAD_N + COMP_N)); // R5

    AST_STORE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> (int'(phase) >= LOAD_N + COMP_N)); // R6

    AST_SINGLE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_en, compute_en, store_en, flush, fetch_req})); // R7

    AST_RUN_HAS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> $onehot({load_en, compute_en, store_en})); // R7

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !write_done) |=> (state == ST_WAIT && $stable(phase))); // R9

    AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && write_done) |=> flush); // R9

    AST_FLUSH_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fetch_req && !flush)); // R11

    AST_FETCH_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> (!fetch_req && state == ST_IDLE)); // R11
endmodule

bind exec_phase_seq exec_seq_checker #(
    .LOAD_N(LOAD_N), .COMP_N(COMP_N), .STORE_N(STORE_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_ready (instr_ready),
    .write_done  (write_done),
    .phase       (phase),
    .load_en     (load_en),
    .compute_en  (compute_en),
    .store_en    (store_en),
    .flush       (flush),
    .fetch_req   (fetch_req),
    .state       (state_q)
);

// File: tb/exec_phase_seq_tb.sv
// Directed bench for the execution phase sequencer. Inputs change and
// outputs are sampled at falling edges.
module exec_phase_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_ready = 1'b0;
    logic       write_done = 1'b0;
    logic [3:0] phase;
    logic       load_en, compute_en, store_en, flush, fetch_req;
    int         total = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    exec_phase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready), .write_done(write_done),
        .phase(phase), .load_en(load_en), .compute_en(compute_en), .store_en(store_en),
        .flush(flush), .fetch_req(fetch_req)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Expects phase p and the given enable/pulse pattern.
    task automatic expect_out(string req, int p, bit l, bit c, bit s, bit f, bit q);
        chk({req, " phase"}, int'(phase), p);
        chk({req, " load_en"}, int'(load_en), int'(l));
        chk({req, " compute_en"}, int'(compute_en), int'(c));
        chk({req, " store_en"}, int'(store_en), int'(s));
        chk({req, " flush"}, int'(flush), int'(f));
        chk({req, " fetch_req"}, int'(fetch_req), int'(q));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        expect_out("R1 reset", 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step();
        expect_out("R2 idle after reset", 0, 0, 0, 0, 0, 0);
    endtask

    // write_done in idle must leave the sequencer idle and unprimed.
    task automatic t_idle_ignore();
        write_done = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            expect_out("R10 idle write_done", 0, 0, 0, 0, 0, 0);
        end
        write_done = 1'b0;
    endtask

    // One instruction: wd_phase is where write_done pulses (-1: none).
    task automatic t_cycle(int wd_phase, bit poke_ready);
        bit early;
        early = (wd_phase >= 12);
        instr_ready = 1'b1;
        step();
        instr_ready = 1'b0;
        for (int p = 0; p < 16; p++) begin
            chk("R3 phase index", int'(phase), p);
            chk("R4 load window", int'(load_en), int'(p < 4));
            chk("R5 compute window", int'(compute_en), int'(p >= 4 && p < 12));
            chk("R6 store window", int'(store_en), int'(p >= 12));
            chk("R7 one group", int'(load_en) + int'(compute_en) + int'(store_en) + int'(flush) + int'(fetch_req), 1);
            write_done  = (p == wd_phase);
            instr_ready = poke_ready && (p == 7 || p == 15);
            step();
        end
        write_done  = 1'b0;
        instr_ready = 1'b0;
        if (early) begin
            chk("R8 flush after store-group write_done", int'(flush), 1);
            chk("R8 no enable in flush", int'(load_en | compute_en | store_en), 0);
        end else begin
            for (int i = 0; i < 3; i++) begin
                expect_out("R9 wait hold", 15, 0, 0, 0, 0, 0);
                instr_ready = poke_ready && (i == 1);
                step();
                instr_ready = 1'b0;
            end
            expect_out("R12 wait ignores instr_ready", 15, 0, 0, 0, 0, 0);
            write_done = 1'b1;
            step();
            write_done = 1'b0;
            chk("R9 flush after late write_done", int'(flush), 1);
        end
        step();
        expect_out("R11 fetch after flush", 0, 0, 0, 0, 0, 1);
        step();
        expect_out("R11 idle after fetch", 0, 0, 0, 0, 0, 0);
        step();
        expect_out("R2 idle holds", 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_idle_ignore();
        t_cycle(-1, 1'b0);  // R9: after idle write_done, must still wait (R10)
        t_cycle(13, 1'b0);  // R8 mid store group
        t_cycle(15, 1'b1);  // R8 at last phase, R12 instr_ready pokes
        t_cycle(6, 1'b1);   // R10 compute-phase write_done ignored, R12 in wait
        t_cycle(12, 1'b0);  // R8 first store phase
        t_reset();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule